// File: doc/BRIEF.md
# Programmable Address Window Decoder

This block steers each bus cycle to a device class by comparing the cycle address against a bank of sixteen programmable windows. Every window is a 32-bit configuration word loaded through a single-cycle write port. The word holds a target class code, a three-bit field, a granularity bit and a packed size-and-base field. The three-bit field is a chip-select index for general-purpose bus targets and three attribute flags for ROM and SDRAM targets. The granularity bit chooses between 4 KB and 64 KB pages for memory cycles. I/O cycles ignore that bit and always use byte granularity over a 64 KB space.

Decoding is combinational from the stored words. A caller presents an address, a memory/I-O flag and a write flag. In the same cycle it receives the winning window index, the target class, the chip-select index, the write-protect, non-cacheable and no-execute flags, and a flag that marks a write into a protected window. The caller uses these to route the cycle and to block illegal writes.

Top module: `addr_win_dec`

## Requirements
- R1: After reset every window word is zero, so every cycle misses. A word written with cfg_we_i high is stored at the next rising clock edge and takes part in decoding from that edge on, and not before it.
- R2: A window whose target code (bits 31:29) is 0 never hits, whatever its other bits hold.
- R3: Target code 3 (PCI) is a memory target only in windows 0 and 1. In any other window, a word with code 3 never hits.
- R4: A memory cycle (is_mem_i=1) matches only windows with target codes 2, 4, 5, 6, 7, or code 3 under R3. An I/O cycle matches only windows with target code 1.
- R5: For a memory cycle with bit 25 = 0, the window covers the address range from B×4096 up to but not including (B+N+1)×4096. Here B is bits 17:0 and N is bits 24:18. Only address bits 29:0 are compared.
- R6: For a memory cycle with bit 25 = 1, the window covers the address range from B×65536 up to but not including (B+N+1)×65536. Here B is bits 13:0 and N is bits 24:14. Only address bits 29:0 are compared.
- R7: For an I/O cycle the window covers the byte range from B up to but not including B+N+1. Here B is bits 15:0 and N is bits 24:16. Bit 25 has no effect, and only address bits 15:0 are compared.
- R8: When several windows match, the lowest-numbered one wins, and its index appears on win_o.
- R9: On a hit in a window with target code 1 or 2, cs_o carries bits 28:26 of that window. For any other target, cs_o is 0.
- R10: On a hit in a window with target code 4 to 7, wp_o, nc_o and nx_o carry bits 28, 27 and 26. For any other target they are 0.
- R11: viol_o is high exactly when a write cycle (is_wr_i=1) hits a window whose wp_o flag is set.
- R12: On a miss, hit_o is 0 and win_o, tgt_o, cs_o, wp_o, nc_o, nx_o and viol_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Window word write strobe |
| cfg_idx_i | input | 4 | Window index to write |
| cfg_wdata_i | input | 32 | Window word to write |
| addr_i | input | 32 | Cycle address |
| is_mem_i | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| is_wr_i | input | 1 | 1 = write cycle |
| hit_o | output | 1 | Some window matched |
| win_o | output | 4 | Index of winning window |
| tgt_o | output | 3 | Target code of winning window |
| cs_o | output | 3 | Chip-select index for general-purpose bus targets |
| wp_o | output | 1 | Write-protected region |
| nc_o | output | 1 | Non-cacheable region |
| nx_o | output | 1 | Code execution denied |
| viol_o | output | 1 | Write into a protected region |

## Verification
Every programmed window is probed at four addresses: one below its base, the base itself, its last unit and the first unit past its end. These probes separate inclusive from exclusive bounds and size-minus-one encoding from plain counts in all three granularities. Each probe is repeated with the unused upper address bits set, as both a memory and an I/O cycle, and as a read and a write. This shows whether the block filters by cycle type, ignores the extra bits and raises the violation flag only on writes. The windows include overlapping pairs and a disabled word with a live range. They also include a PCI code placed outside the first two slots, an I/O window with the granularity bit set, and a window that ends at the top of the 30-bit space. A later rewrite of one window checks write timing and shows that priority falls through to the next window.

// File: rtl/addr_win_pkg.sv
package addr_win_pkg;
  typedef enum logic [2:0] {
    TGT_OFF    = 3'd0,
    TGT_GP_IO  = 3'd1,
    TGT_GP_MEM = 3'd2,
    TGT_PCI    = 3'd3,
    TGT_BOOT   = 3'd4,
    TGT_ROM1   = 3'd5,
    TGT_ROM2   = 3'd6,
    TGT_SDRAM  = 3'd7
  } tgt_e;

  localparam int unsigned CFG_W = 32;
  localparam int unsigned FLD_W = 26;  // granularity bit + size/base
endpackage

// File: rtl/addr_win_regs.sv
module addr_win_regs #(
  parameter int unsigned N_WIN = 16,
  parameter int unsigned IDX_W = $clog2(N_WIN)
) (
  input  logic                                      clk_i,
  input  logic                                      rst_ni,
  input  logic                                      we_i,
  input  logic [IDX_W-1:0]                          idx_i,
  input  logic [addr_win_pkg::CFG_W-1:0]            wdata_i,
  output logic [N_WIN-1:0][addr_win_pkg::CFG_W-1:0] cfg_o
);
  for (genvar g = 0; g < N_WIN; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              cfg_o[g] <= '0;
      else if (we_i && idx_i == IDX_W'(g))      cfg_o[g] <= wdata_i;
    end
  end

  AST_CFG_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> cfg_o[$past(idx_i)] == $past(wdata_i)); // R1
endmodule

// File: rtl/addr_win_match.sv
module addr_win_match
  import addr_win_pkg::*;
#(
  parameter int unsigned WIN_IDX = 0
) (
  input  logic [2:0]       tgt_i,
  input  logic [FLD_W-1:0] fld_i,
  input  logic [29:0]      addr_i,
  input  logic             is_mem_i,
  output logic             hit_o
);
  localparam bit PCI_OK = (WIN_IDX < 2);

  logic [17:0] off_4k;
  logic [13:0] off_64k;
  logic [15:0] off_io;
  logic        in_4k, in_64k, in_io, mem_tgt;

  // compare in units of the granularity: base <= a and a-base <= count
  always_comb begin
    off_4k  = addr_i[29:12] - fld_i[17:0];
    off_64k = addr_i[29:16] - fld_i[13:0];
    off_io  = addr_i[15:0]  - fld_i[15:0];
    in_4k   = (addr_i[29:12] >= fld_i[17:0]) && (off_4k  <= {11'b0, fld_i[24:18]});
    in_64k  = (addr_i[29:16] >= fld_i[13:0]) && (off_64k <= {3'b0, fld_i[24:14]});
    in_io   = (addr_i[15:0]  >= fld_i[15:0]) && (off_io  <= {7'b0, fld_i[24:16]});
    unique case (tgt_e'(tgt_i))
      TGT_GP_MEM, TGT_BOOT, TGT_ROM1, TGT_ROM2, TGT_SDRAM: mem_tgt = 1'b1;
      TGT_PCI: mem_tgt = PCI_OK;
      default: mem_tgt = 1'b0;
    endcase
    if (is_mem_i) hit_o = mem_tgt && (fld_i[25] ? in_64k : in_4k);
    else          hit_o = (tgt_e'(tgt_i) == TGT_GP_IO) && in_io;
  end
endmodule

// File: rtl/addr_win_pick.sv
module addr_win_pick #(
  parameter int unsigned N_WIN = 16,
  parameter int unsigned IDX_W = $clog2(N_WIN)
) (
  input  logic [N_WIN-1:0] hit_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  // scan downward so the lowest set bit is written last
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = N_WIN - 1; i >= 0; i--) begin
      if (hit_i[i]) begin
        any_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/addr_win_dec.sv
module addr_win_dec
  import addr_win_pkg::*;
#(
  parameter int unsigned N_WIN = 16,
  parameter int unsigned IDX_W = $clog2(N_WIN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [IDX_W-1:0] cfg_idx_i,
  input  logic [31:0]      cfg_wdata_i,
  input  logic [31:0]      addr_i,
  input  logic             is_mem_i,
  input  logic             is_wr_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] win_o,
  output logic [2:0]       tgt_o,
  output logic [2:0]       cs_o,
  output logic             wp_o,
  output logic             nc_o,
  output logic             nx_o,
  output logic             viol_o
);
  logic [N_WIN-1:0][CFG_W-1:0] cfg_q;
  logic [N_WIN-1:0]            hit_vec;
  logic                        any_hit;
  logic [IDX_W-1:0]            sel_idx;
  logic [5:0]                  sel_hi;
  logic                        is_gp, is_rom;
  logic [1:0]                  unused_addr;

  assign unused_addr = addr_i[31:30];

  addr_win_regs #(.N_WIN(N_WIN), .IDX_W(IDX_W)) regs_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .idx_i  (cfg_idx_i),
    .wdata_i(cfg_wdata_i),
    .cfg_o  (cfg_q)
  );

  for (genvar g = 0; g < N_WIN; g++) begin : g_win
    addr_win_match #(.WIN_IDX(g)) match_i (
      .tgt_i   (cfg_q[g][31:29]),
      .fld_i   (cfg_q[g][FLD_W-1:0]),
      .addr_i  (addr_i[29:0]),
      .is_mem_i(is_mem_i),
      .hit_o   (hit_vec[g])
    );
  end

  addr_win_pick #(.N_WIN(N_WIN), .IDX_W(IDX_W)) pick_i (
    .hit_i(hit_vec),
    .any_o(any_hit),
    .idx_o(sel_idx)
  );

  always_comb begin
    sel_hi = any_hit ? cfg_q[sel_idx][31:26] : '0;
    is_gp  = (sel_hi[5:3] == TGT_GP_IO) || (sel_hi[5:3] == TGT_GP_MEM);
    is_rom = sel_hi[5];
    hit_o  = any_hit;
    win_o  = any_hit ? sel_idx : '0;
    tgt_o  = sel_hi[5:3];
    cs_o   = is_gp ? sel_hi[2:0] : '0;
    wp_o   = is_rom & sel_hi[2];
    nc_o   = is_rom & sel_hi[1];
    nx_o   = is_rom & sel_hi[0];
    viol_o = is_wr_i & wp_o;
  end

  AST_MISS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (win_o == '0 && tgt_o == '0 && cs_o == '0 && !wp_o && !nc_o && !nx_o && !viol_o)); // R12
  AST_OFF_NO_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> tgt_o != TGT_OFF); // R2
  AST_PCI_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && tgt_o == TGT_PCI) |-> (win_o < 2 && is_mem_i)); // R3
  AST_IO_GP_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && !is_mem_i) |-> tgt_o == TGT_GP_IO); // R4
  AST_CS_GP_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_o != '0) |-> (tgt_o == TGT_GP_IO || tgt_o == TGT_GP_MEM)); // R9
  AST_ATTR_ROM_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wp_o || nc_o || nx_o) |-> tgt_o[2]); // R10
  AST_VIOL_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o |-> (is_wr_i && wp_o && hit_o)); // R11
endmodule

// File: tb/addr_win_dec_tb_top.sv
`timescale 1ns/1ps
module addr_win_dec_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_idx = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] addr = '0;
  logic        is_mem = 1'b1;
  logic        is_wr = 1'b0;
  logic        hit_o;
  logic [3:0]  win_o;
  logic [2:0]  tgt_o, cs_o;
  logic        wp_o, nc_o, nx_o, viol_o;

  int total = 0;
  int bad = 0;
  logic [31:0] shadow [16];

  always #5 clk = ~clk;

  addr_win_dec dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx),
    .cfg_wdata_i(cfg_wdata), .addr_i(addr), .is_mem_i(is_mem), .is_wr_i(is_wr),
    .hit_o(hit_o), .win_o(win_o), .tgt_o(tgt_o), .cs_o(cs_o),
    .wp_o(wp_o), .nc_o(nc_o), .nx_o(nx_o), .viol_o(viol_o)
  );

  function automatic logic [31:0] mk_m4(int t, int a, int n, int b);
    return {3'(t), 3'(a), 1'b0, 7'(n), 18'(b)};
  endfunction
  function automatic logic [31:0] mk_m64(int t, int a, int n, int b);
    return {3'(t), 3'(a), 1'b1, 11'(n), 14'(b)};
  endfunction
  function automatic logic [31:0] mk_io(int t, int a, bit g, int n, int b);
    return {3'(t), 3'(a), g, 9'(n), 16'(b)};
  endfunction

  function automatic void span(int w, bit mem, output longint st, output longint sz);
    logic [31:0] c = shadow[w];
    if (!mem)      begin st = longint'(c[15:0]);         sz = longint'(c[24:16]) + 1; end
    else if (c[25]) begin st = longint'(c[13:0]) * 65536; sz = (longint'(c[24:14]) + 1) * 65536; end
    else           begin st = longint'(c[17:0]) * 4096;  sz = (longint'(c[24:18]) + 1) * 4096; end
  endfunction

  // expected {hit,win,tgt,cs,wp,nc,nx,viol}
  function automatic logic [14:0] model(logic [31:0] a, bit mem, bit wr);
    longint st, sz, av;
    for (int w = 0; w < 16; w++) begin
      int t = int'(shadow[w][31:29]);
      bit ok;
      if (mem) ok = (t == 2) || (t >= 4) || (t == 3 && w < 2);
      else     ok = (t == 1);
      if (!ok) continue;
      span(w, mem, st, sz);
      av = mem ? longint'(a[29:0]) : longint'(a[15:0]);
      if (av >= st && av < st + sz) begin
        logic [2:0] f = shadow[w][28:26];
        logic [2:0] cs = (t == 1 || t == 2) ? f : 3'd0;
        logic [2:0] at = (t >= 4) ? f : 3'd0;
        return {1'b1, 4'(w), 3'(t), cs, at, wr & at[2]};
      end
    end
    return '0;
  endfunction

  function automatic string tag_of(logic [14:0] e, bit mem, int w);
    if (!e[14])  return "R12";
    if (e[0])    return "R11";
    if (!mem)    return "R7";
    if (e[9:7] == 3'd3) return "R3";
    return shadow[w][25] ? "R6" : "R5";
  endfunction

  task automatic chk(string tag, logic [14:0] exp);
    logic [14:0] got = {hit_o, win_o, tgt_o, cs_o, wp_o, nc_o, nx_o, viol_o};
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s addr=%h mem=%0b wr=%0b got=%h exp=%h", tag, addr, is_mem, is_wr, got, exp);
    end
  endtask

  task automatic probe(string tag, logic [31:0] a, bit mem, bit wr);
    @(negedge clk);
    addr = a; is_mem = mem; is_wr = wr;
    #1;
    chk(tag, model(a, mem, wr));
  endtask

  task automatic wr_cfg(int w, logic [31:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 4'(w); cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
    shadow[w] = v;
  endtask

  task automatic sweep();
    longint st, sz;
    for (int w = 0; w < 16; w++) begin
      if (shadow[w][31:29] == 3'd0) continue;
      for (int m = 0; m < 2; m++) begin
        span(w, m == 1, st, sz);
        for (int k = 0; k < 4; k++) begin
          longint p = (k == 0) ? st - 1 : (k == 1) ? st : (k == 2) ? st + sz - 1 : st + sz;
          for (int hi = 0; hi < 2; hi++) begin
            logic [31:0] a = 32'(p) | (hi == 1 ? (m == 1 ? 32'hC000_0000 : 32'hABCD_0000) : 32'h0);
            for (int r = 0; r < 2; r++) begin
              logic [14:0] e = model(a, m == 1, r == 1);
              @(negedge clk);
              addr = a; is_mem = (m == 1); is_wr = (r == 1);
              #1;
              chk(tag_of(e, m == 1, int'(e[13:10])), e);
            end
          end
        end
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int w = 0; w < 16; w++) shadow[w] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state, every window disabled
    probe("R1", 32'h0000_0000, 1'b1, 1'b0);
    probe("R1", 32'h0010_0000, 1'b1, 1'b1);
    probe("R1", 32'h0000_0300, 1'b0, 1'b0);

    // R1: write visible only after the edge
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 4'd0; cfg_wdata = mk_m4(3, 0, 3, 'h00100);
    addr = 32'h0010_0000; is_mem = 1'b1; is_wr = 1'b0;
    #1 chk("R1", 15'd0);
    @(negedge clk);
    cfg_we = 1'b0;
    shadow[0] = mk_m4(3, 0, 3, 'h00100);
    #1 chk("R1", {1'b1, 4'd0, 3'd3, 3'd0, 3'd0, 1'b0});

    wr_cfg(1,  mk_m64(7, 3'b100, 1, 'h0040));
    wr_cfg(2,  mk_m4(0, 0, 127, 'h00200));
    wr_cfg(3,  mk_m4(3, 0, 0, 'h00300));
    wr_cfg(4,  mk_io(1, 2, 1'b0, 15, 'h0300));
    wr_cfg(5,  mk_m4(2, 5, 127, 'h00500));
    wr_cfg(6,  mk_m4(6, 3'b010, 3, 'h00410));
    wr_cfg(7,  mk_m64(4, 3'b011, 0, 'h3FFF));
    wr_cfg(8,  mk_io(1, 7, 1'b1, 511, 'hFFF0));
    wr_cfg(9,  mk_m64(2, 1, 2047, 'h1000));
    wr_cfg(10, mk_io(1, 3, 1'b0, 3, 'h0308));
    wr_cfg(11, mk_m4(7, 3'b111, 0, 'h20000));
    wr_cfg(12, mk_m64(5, 0, 4, 'h2100));

    // directed cases with named requirements
    probe("R2", 32'h0020_0000, 1'b1, 1'b0);
    probe("R2", 32'h0027_F000, 1'b1, 1'b1);
    probe("R3", 32'h0030_0000, 1'b1, 1'b0);
    probe("R3", 32'h0010_0000, 1'b0, 1'b0);
    probe("R4", 32'h0050_0000, 1'b0, 1'b0);
    probe("R4", 32'h0000_0300, 1'b1, 1'b0);
    probe("R8", 32'h0041_0000, 1'b1, 1'b0);
    probe("R8", 32'h0000_0309, 1'b0, 1'b0);
    probe("R9", 32'h0050_1234, 1'b1, 1'b0);
    probe("R9", 32'h1000_0000, 1'b1, 1'b1);
    probe("R10", 32'h3FFF_8000, 1'b1, 1'b0);
    probe("R10", 32'h2000_0FFF, 1'b1, 1'b0);
    probe("R11", 32'h0040_0000, 1'b1, 1'b1);
    probe("R11", 32'h2000_0000, 1'b1, 1'b1);
    probe("R11", 32'h0040_0000, 1'b1, 1'b0);
    probe("R7", 32'h0000_FFFF, 1'b0, 1'b0);
    probe("R7", 32'h0000_01EF, 1'b0, 1'b0);
    probe("R12", 32'h0800_0000, 1'b1, 1'b0);

    sweep();

    // R8: removing the winner lets the next window take over
    wr_cfg(1, 32'h0);
    probe("R8", 32'h0041_0000, 1'b1, 1'b1);
    probe("R8", 32'h0040_0000, 1'b1, 1'b0);
    wr_cfg(4, 32'h0);
    probe("R8", 32'h0000_0309, 1'b0, 1'b0);
    sweep();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule